// File: doc/BRIEF.md
# Segment Relocation and Protection Unit

This unit sits on the address path between a processor and its memory. Each bus cycle carries a 3-bit function code. The unit uses that code to decide what kind of cycle is under way. User cycles go to one of three segments: data, program or stack. Each segment has its own base register and its own limit register.

For a user cycle, the logical address is checked against the segment's limit. If the address is in range, the segment's base is added to it and the sum goes to memory. If the address is out of range, the unit raises a bus error and does not forward the memory strobe.

Supervisor cycles and interrupt-acknowledge cycles pass through unchanged. The registers are loaded by supervisor-data accesses to a small reserved address window. This lets a fault handler widen the stack limit and then re-run the probe read that faulted. The unit has no page tables and gives no instruction-restart support.

Top module: `seg_reloc_unit`

## Requirements
- R1: After reset, all outputs are 0 and every base and limit register is 0. The first user access after reset therefore raises a bus error.
- R2: The function code selects the segment:
  - Code 1 (user data) with logical address MSB 0 selects the data segment.
  - Code 1 with MSB 1 selects the stack segment.
  - Code 2 (user program) selects the program segment.
- R3: A legal user access gives `phys_addr_o = base + logical address`, reduced modulo 2^PW, with `mem_strobe_o` high. These outputs appear in the cycle after the edge that sampled `as_i`.
- R4: For the data and program segments, an access is legal only if the address is below the segment's limit. Otherwise `bus_err_o` is 1 and `mem_strobe_o` is 0.
- R5: The stack segment grows downward. An access is legal only if 2^AW minus the address is at most the stack limit. Raising the limit makes a probe that failed before succeed.
- R6: The following cycles are forwarded unchecked, with `phys_addr_o` equal to the zero-extended address and no error:
  - code 6 (supervisor program);
  - code 5 (supervisor data) outside the register window.
- R7: Code 7 (interrupt acknowledge) is forwarded unchecked and unrelocated, whatever the register contents.
- R8: Codes 0, 3 and 4 raise a bus error and give no strobe.
- R9: A code 5 cycle whose address bits [AW-1:3] equal WIN_TAG is a register cycle; the default window is 0xFFF8 to 0xFFFF.
  - Such a cycle gives neither a strobe nor an error.
  - If `wr_i` is 1, it writes `wdata_i` to the register chosen by address bits [2:0]: 0 data base, 1 data limit, 2 program base, 3 program limit, 4 stack base, 5 stack limit. A limit takes the low AW bits.
  - The new value governs the very next access.
- R10: The following leave all registers unchanged:
  - window indexes 6 and 7;
  - writes to window addresses under any other function code.
- R11: A cycle with `as_i` low gives `mem_strobe_o = 0`, `bus_err_o = 0` and `phys_addr_o = 0` in the following cycle.
- R12: `mem_strobe_o` and `bus_err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| as_i | input | 1 | Address strobe: a bus cycle is present |
| wr_i | input | 1 | 1 for a write cycle |
| fc_i | input | 3 | Function code of the cycle |
| addr_i | input | AW | Logical address |
| wdata_i | input | PW | Write data for register cycles |
| phys_addr_o | output | PW | Physical address (registered) |
| mem_strobe_o | output | 1 | Forwarded memory strobe (registered) |
| bus_err_o | output | 1 | Bus error response (registered) |

## Verification
Every response is registered once: a cycle sampled at a rising edge shows its address, strobe and error after that edge, and they hold for that one cycle. A register write that is sampled at an edge governs the access sampled at the next edge. The bench drives each cycle at a falling edge and reads the outputs at the following falling edge, midway between the sampling edge and the next one. Stack growth is checked as a fault, then a limit write, then the same probe again, in three back-to-back cycles.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;
    // segment kinds; user kinds first so their value indexes the register bank
    typedef enum logic [2:0] {
        SEG_DATA  = 3'd0,
        SEG_PROG  = 3'd1,
        SEG_STACK = 3'd2,
        SEG_SUPV  = 3'd3,
        SEG_IACK  = 3'd4,
        SEG_BAD   = 3'd5
    } seg_kind_e;

    localparam int unsigned USEG_N = 3;

    localparam logic [2:0] FC_UDATA = 3'd1;
    localparam logic [2:0] FC_UPROG = 3'd2;
    localparam logic [2:0] FC_SDATA = 3'd5;
    localparam logic [2:0] FC_SPROG = 3'd6;
    localparam logic [2:0] FC_IACK  = 3'd7;
endpackage

// File: rtl/seg_cycle_decode.sv
module seg_cycle_decode
    import seg_reloc_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter logic [AW-4:0] WIN_TAG = '1
) (
    input  logic [2:0]    fc_i,
    input  logic [AW-1:0] addr_i,
    output seg_kind_e     kind_o,
    output logic          win_hit_o
);
    always_comb begin
        case (fc_i)
            FC_UDATA:          kind_o = addr_i[AW-1] ? SEG_STACK : SEG_DATA;
            FC_UPROG:          kind_o = SEG_PROG;
            FC_SDATA, FC_SPROG: kind_o = SEG_SUPV;
            FC_IACK:           kind_o = SEG_IACK;
            default:           kind_o = SEG_BAD;
        endcase
        win_hit_o = (fc_i == FC_SDATA) && (addr_i[AW-1:3] == WIN_TAG);
    end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
    import seg_reloc_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned PW = 20
) (
    input  seg_kind_e     kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic [PW-1:0] base_i,
    input  logic [AW-1:0] limit_i,
    output logic          legal_o,
    output logic [PW-1:0] phys_o
);
    localparam logic [AW:0] SEG_TOP = {1'b1, {AW{1'b0}}};

    logic [AW:0] depth;

    always_comb begin
        phys_o = base_i + PW'(addr_i);
        depth  = SEG_TOP - {1'b0, addr_i};
        case (kind_i)
            SEG_DATA, SEG_PROG: legal_o = (addr_i < limit_i);
            SEG_STACK:          legal_o = (depth <= {1'b0, limit_i});
            default:            legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/seg_reg_bank.sv
module seg_reg_bank
    import seg_reloc_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned PW = 20
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_en_i,
    input  logic [2:0]                    wr_idx_i,
    input  logic [PW-1:0]                 wdata_i,
    output logic [USEG_N-1:0][PW-1:0]     base_o,
    output logic [USEG_N-1:0][AW-1:0]     limit_o
);
    typedef struct packed {
        logic [USEG_N-1:0][PW-1:0] base;
        logic [USEG_N-1:0][AW-1:0] limit;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [USEG_N-1:0] seg_sel;

    for (genvar g = 0; g < USEG_N; g++) begin : g_sel
        assign seg_sel[g] = wr_en_i && (wr_idx_i[2:1] == 2'(g));
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < USEG_N; i++) begin
            if (seg_sel[i]) begin
                if (wr_idx_i[0]) bank_d.limit[i] = wdata_i[AW-1:0];
                else             bank_d.base[i]  = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) bank_q <= '0;
        else         bank_q <= bank_d;
    end

    assign base_o  = bank_q.base;
    assign limit_o = bank_q.limit;

    // R10
    bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(bank_q));
endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
    import seg_reloc_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned PW = 20,
    parameter logic [AW-4:0] WIN_TAG = '1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          as_i,
    input  logic          wr_i,
    input  logic [2:0]    fc_i,
    input  logic [AW-1:0] addr_i,
    input  logic [PW-1:0] wdata_i,
    output logic [PW-1:0] phys_addr_o,
    output logic          mem_strobe_o,
    output logic          bus_err_o
);
    typedef struct packed {
        logic [PW-1:0] phys;
        logic          stb;
        logic          err;
    } resp_t;

    seg_kind_e                 kind;
    logic                      win_hit;
    logic                      reg_wr;
    logic [USEG_N-1:0][PW-1:0] base_arr;
    logic [USEG_N-1:0][AW-1:0] limit_arr;
    logic [PW-1:0]             base_sel;
    logic [AW-1:0]             limit_sel;
    logic                      legal;
    logic [PW-1:0]             reloc;
    resp_t                     resp_d, resp_q;

    seg_cycle_decode #(.AW(AW), .WIN_TAG(WIN_TAG)) u_decode (
        .fc_i      (fc_i),
        .addr_i    (addr_i),
        .kind_o    (kind),
        .win_hit_o (win_hit)
    );

    assign reg_wr = as_i && wr_i && win_hit;

    seg_reg_bank #(.AW(AW), .PW(PW)) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (reg_wr),
        .wr_idx_i (addr_i[2:0]),
        .wdata_i  (wdata_i),
        .base_o   (base_arr),
        .limit_o  (limit_arr)
    );

    always_comb begin
        base_sel  = '0;
        limit_sel = '0;
        for (int i = 0; i < USEG_N; i++) begin
            if (kind == seg_kind_e'(i)) begin
                base_sel  = base_arr[i];
                limit_sel = limit_arr[i];
            end
        end
    end

    seg_limit_check #(.AW(AW), .PW(PW)) u_check (
        .kind_i  (kind),
        .addr_i  (addr_i),
        .base_i  (base_sel),
        .limit_i (limit_sel),
        .legal_o (legal),
        .phys_o  (reloc)
    );

    always_comb begin
        resp_d = '0;
        if (as_i) begin
            case (kind)
                SEG_DATA, SEG_PROG, SEG_STACK: begin
                    if (legal) begin
                        resp_d.phys = reloc;
                        resp_d.stb  = 1'b1;
                    end else begin
                        resp_d.err  = 1'b1;
                    end
                end
                SEG_SUPV: begin
                    if (!win_hit) begin
                        resp_d.phys = PW'(addr_i);
                        resp_d.stb  = 1'b1;
                    end
                end
                SEG_IACK: begin
                    resp_d.phys = PW'(addr_i);
                    resp_d.stb  = 1'b1;
                end
                default: resp_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) resp_q <= '0;
        else         resp_q <= resp_d;
    end

    assign phys_addr_o  = resp_q.phys;
    assign mem_strobe_o = resp_q.stb;
    assign bus_err_o    = resp_q.err;

    // R12
    strobe_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_strobe_o && bus_err_o));

    // R11
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !as_i |=> (!mem_strobe_o && !bus_err_o));

    // R6
    supv_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (as_i && fc_i == FC_SPROG) |=> (mem_strobe_o && phys_addr_o == PW'($past(addr_i))));

    // R7
    iack_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (as_i && fc_i == FC_IACK) |=> (mem_strobe_o && !bus_err_o && phys_addr_o == PW'($past(addr_i))));

    // R8
    bad_fc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (as_i && (fc_i == 3'd0 || fc_i == 3'd3 || fc_i == 3'd4)) |=> bus_err_o);

    // R9
    reg_cycle_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (as_i && win_hit) |=> (!mem_strobe_o && !bus_err_o));
endmodule

// File: tb/seg_reloc_unit_tb.sv
module seg_reloc_unit_tb;
    localparam int AW = 16;
    localparam int PW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          as_i = 1'b0;
    logic          wr_i = 1'b0;
    logic [2:0]    fc_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic [PW-1:0] wdata_i = '0;
    logic [PW-1:0] phys;
    logic          stb;
    logic          err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    seg_reloc_unit #(.AW(AW), .PW(PW)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .as_i         (as_i),
        .wr_i         (wr_i),
        .fc_i         (fc_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .phys_addr_o  (phys),
        .mem_strobe_o (stb),
        .bus_err_o    (err)
    );

    task automatic expect_out(string req, logic [PW-1:0] ep, logic es, logic ee);
        n_chk++;
        if (phys !== ep || stb !== es || err !== ee) begin
            n_bad++;
            $display("FAIL %s: phys=%h stb=%b err=%b expected phys=%h stb=%b err=%b",
                     req, phys, stb, err, ep, es, ee);
        end
    endtask

    // called right after a falling edge; returns at the falling edge where results show
    task automatic cyc(logic [2:0] fc, logic [AW-1:0] a, logic w, logic [PW-1:0] d);
        as_i = 1'b1; fc_i = fc; addr_i = a; wr_i = w; wdata_i = d;
        @(negedge clk);
        as_i = 1'b0; wr_i = 1'b0;
    endtask

    task automatic wreg(logic [2:0] idx, logic [PW-1:0] v);
        cyc(3'd5, {13'h1FFF, idx}, 1'b1, v);
        expect_out("R9 write claims cycle", '0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        expect_out("R1 outputs in reset", '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(3'd1, 16'h0000, 1'b0, '0);
        expect_out("R1 zero limit faults", '0, 1'b0, 1'b1);
        cyc(3'd1, 16'hFFFF, 1'b0, '0);
        expect_out("R1 zero stack limit faults", '0, 1'b0, 1'b1);
    endtask

    task automatic t_data_seg();
        wreg(3'd0, 20'h10000);
        wreg(3'd1, 20'h00100);
        cyc(3'd1, 16'h00FF, 1'b0, '0);
        expect_out("R3 data relocation", 20'h100FF, 1'b1, 1'b0);
        cyc(3'd1, 16'h0100, 1'b0, '0);
        expect_out("R4 data at limit faults", '0, 1'b0, 1'b1);
        cyc(3'd1, 16'h0000, 1'b0, '0);
        expect_out("R2 data segment low", 20'h10000, 1'b1, 1'b0);
    endtask

    task automatic t_prog_seg();
        wreg(3'd2, 20'hFFF00);
        wreg(3'd3, 20'h08000);
        cyc(3'd2, 16'h0200, 1'b0, '0);
        expect_out("R3 program wrap", 20'h00100, 1'b1, 1'b0);
        cyc(3'd2, 16'h7FFF, 1'b0, '0);
        expect_out("R4 program last legal", 20'h07EFF, 1'b1, 1'b0);
        cyc(3'd2, 16'h8000, 1'b0, '0);
        expect_out("R4 program at limit", '0, 1'b0, 1'b1);
    endtask

    task automatic t_stack_grow();
        wreg(3'd4, 20'h20000);
        wreg(3'd5, 20'h00010);
        cyc(3'd1, 16'hFFF0, 1'b0, '0);
        expect_out("R5 stack deepest legal", 20'h2FFF0, 1'b1, 1'b0);
        cyc(3'd1, 16'hFFEF, 1'b0, '0);
        expect_out("R5 stack probe faults", '0, 1'b0, 1'b1);
        wreg(3'd5, 20'h00020);
        cyc(3'd1, 16'hFFEF, 1'b0, '0);
        expect_out("R5 probe after grow", 20'h2FFEF, 1'b1, 1'b0);
        cyc(3'd1, 16'hFFE0, 1'b0, '0);
        expect_out("R5 new bottom", 20'h2FFE0, 1'b1, 1'b0);
        cyc(3'd1, 16'hFFDF, 1'b0, '0);
        expect_out("R5 below new bottom", '0, 1'b0, 1'b1);
        cyc(3'd1, 16'h7FFF, 1'b0, '0);
        expect_out("R2 MSB0 stays data segment", '0, 1'b0, 1'b1);
    endtask

    task automatic t_supv();
        cyc(3'd5, 16'h1234, 1'b0, '0);
        expect_out("R6 supervisor data pass", 20'h01234, 1'b1, 1'b0);
        cyc(3'd5, 16'hFFF7, 1'b1, 20'h55555);
        expect_out("R6 just below window", 20'h0FFF7, 1'b1, 1'b0);
        cyc(3'd6, 16'hFFF8, 1'b1, 20'h55555);
        expect_out("R6 supervisor program pass", 20'h0FFF8, 1'b1, 1'b0);
        cyc(3'd5, 16'hFFF9, 1'b0, '0);
        expect_out("R9 window read claimed", '0, 1'b0, 1'b0);
    endtask

    task automatic t_iack();
        cyc(3'd7, 16'hFFFF, 1'b0, '0);
        expect_out("R7 iack unrelocated", 20'h0FFFF, 1'b1, 1'b0);
        cyc(3'd7, 16'h0400, 1'b0, '0);
        expect_out("R7 iack beyond limits", 20'h00400, 1'b1, 1'b0);
    endtask

    task automatic t_bad_fc();
        cyc(3'd0, 16'h0010, 1'b0, '0);
        expect_out("R8 code 0", '0, 1'b0, 1'b1);
        cyc(3'd3, 16'h0010, 1'b0, '0);
        expect_out("R8 code 3", '0, 1'b0, 1'b1);
        cyc(3'd4, 16'h0010, 1'b0, '0);
        expect_out("R8 code 4", '0, 1'b0, 1'b1);
    endtask

    task automatic t_window_rules();
        cyc(3'd1, 16'hFFF8, 1'b1, 20'hAAAAA);
        expect_out("R10 user write to window is a stack access", 20'h2FFF8, 1'b1, 1'b0);
        cyc(3'd6, 16'hFFF9, 1'b1, 20'h00000);
        expect_out("R10 program-space write passes", 20'h0FFF9, 1'b1, 1'b0);
        wreg(3'd6, 20'h12345);
        wreg(3'd7, 20'h00000);
        cyc(3'd1, 16'h00FF, 1'b0, '0);
        expect_out("R10 data base and limit kept", 20'h100FF, 1'b1, 1'b0);
        cyc(3'd1, 16'h0100, 1'b0, '0);
        expect_out("R10 data limit kept", '0, 1'b0, 1'b1);
        cyc(3'd2, 16'h7FFF, 1'b0, '0);
        expect_out("R10 program regs kept", 20'h07EFF, 1'b1, 1'b0);
        cyc(3'd1, 16'hFFE0, 1'b0, '0);
        expect_out("R10 stack regs kept", 20'h2FFE0, 1'b1, 1'b0);
    endtask

    task automatic t_idle();
        cyc(3'd1, 16'h0001, 1'b0, '0);
        expect_out("R3 data before idle", 20'h10001, 1'b1, 1'b0);
        fc_i = 3'd1; addr_i = 16'h0002;
        @(negedge clk);
        expect_out("R11 idle cycle quiet", '0, 1'b0, 1'b0);
        fc_i = 3'd0;
        @(negedge clk);
        expect_out("R11 idle with bad code quiet", '0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_data_seg();
        t_prog_seg();
        t_stack_grow();
        t_supv();
        t_iack();
        t_bad_fc();
        t_window_rules();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule